// File: doc/BRIEF.md
# Mode Control and Coprocessor Trap Logic

This block keeps the processor's mode-control word: the protection and paging enables, supervisor write protection, the numeric-error reporting choice, and the four bits that govern the floating-point coprocessor. Privileged software writes the word through a single write port. The block turns away a write that would turn paging on while protection stays off. It drives a one-cycle general-protection pulse for that write.

A task-switch strobe from the task logic sets the task-switched bit. Software clears that bit, either by writing the word or through a dedicated clear strobe. The instruction decoder reports each instruction's class with a valid strobe. The block answers one cycle later with a device-not-available pulse when a floating-point or wait instruction must trap. It also drives two signals that other units read: the effective paging enable, and a 32-bit coprocessor protocol indication.

Top module: `mode_ctrl_trap`

## Requirements
- R1: While reset is held, the control word reads 0 except bit 4 (extension type), which takes the value of the `cop32_strap` input. `paging_on` and `dna_pulse` read 0.
- R2: A legal write stores bits 0 (protect enable), 1 (monitor), 2 (emulate), 3 (task switched), 4 (extension type), 5 (numeric error), 16 (write protect) and 31 (paging), and the word shows them after the next clock edge. Every other bit always reads 0.
- R3: A write with bit 31 = 1 and bit 0 = 0 is illegal. It leaves the word unchanged, and `gp_pulse` is 1 for exactly the one cycle that follows the write.
- R4: `ts_event` sets bit 3. It wins over `ts_clear` and over a write of bit 3 = 0 that arrive in the same cycle.
- R5: `ts_clear` clears bit 3 when it arrives without `ts_event` and without a legal write. A legal write in the same cycle wins over `ts_clear`.
- R6: A valid floating-point instruction (class 2'b01) with emulate = 1 gives `dna_pulse` = 1 in the following cycle.
- R7: A valid floating-point instruction with emulate = 0 gives `dna_pulse` = 1 if task switched = 1, and 0 if task switched = 0.
- R8: A valid wait instruction (class 2'b10) gives `dna_pulse` = 1 only when monitor and task switched are both 1. With monitor = 0, task switched has no effect on it.
- R9: Class 2'b00 and class 2'b11 never give `dna_pulse`, and neither does any class presented with `insn_valid` = 0.
- R10: `paging_on` is 1 exactly when bits 31 and 0 of the word are both 1.
- R11: `cop32_on` equals the extension-type bit while emulate = 0, and is 0 while emulate = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cop32_strap | input | 1 | 32-bit coprocessor present strap, sampled at reset |
| wr_en | input | 1 | Privileged write strobe |
| wr_data | input | 32 | Value to write |
| ts_event | input | 1 | Task-switch event |
| ts_clear | input | 1 | Clear task-switched bit |
| insn_valid | input | 1 | Instruction class is valid |
| insn_class | input | 2 | 00 other, 01 floating point, 10 wait, 11 other |
| ctrl_q | output | 32 | Control word |
| dna_pulse | output | 1 | Device-not-available trap, one cycle |
| gp_pulse | output | 1 | General-protection trap for an illegal write |
| paging_on | output | 1 | Effective paging enable |
| cop32_on | output | 1 | 32-bit coprocessor protocol in use |

## Verification
The hardest case to reach is a collision on the task-switched bit. That happens when a task switch, a clear strobe and a software write all reach bit 3 in the same cycle. The stimulus drives these strobes together in every pairing and reads the resulting word. A table walk sets the emulate, monitor and task-switched bits through legal writes, then issues each instruction class under those settings. An illegal write is placed right after a known legal value, so that the unchanged word can be seen.

// File: rtl/mode_ctrl_trap.sv
module mode_ctrl_trap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cop32_strap,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ts_event,
  input  logic         ts_clear,
  input  logic         insn_valid,
  input  logic [1:0]   insn_class,
  output logic [W-1:0] ctrl_q,
  output logic         dna_pulse,
  output logic         gp_pulse,
  output logic         paging_on,
  output logic         cop32_on
);
  localparam int B_PE = 0, B_MP = 1, B_EM = 2, B_TS = 3, B_ET = 4, B_NE = 5;
  localparam int B_WP = 16, B_PG = W - 1;
  localparam logic [W-1:0] MASK = (W'(1) << B_PE) | (W'(1) << B_MP) | (W'(1) << B_EM)
                                | (W'(1) << B_TS) | (W'(1) << B_ET) | (W'(1) << B_NE)
                                | (W'(1) << B_WP) | (W'(1) << B_PG);
  localparam logic [1:0] CLS_FP = 2'b01, CLS_WAIT = 2'b10;

  logic wr_bad, wr_ok, ts_next, fp_trap, wait_trap;
  logic [W-1:0] word_next;

  assign wr_bad = wr_en && wr_data[B_PG] && !wr_data[B_PE];
  assign wr_ok  = wr_en && !wr_bad;

  always_comb begin
    word_next = wr_ok ? (wr_data & MASK) : ctrl_q;
    if (ts_event)                ts_next = 1'b1;
    else if (wr_ok)              ts_next = wr_data[B_TS];
    else if (ts_clear)           ts_next = 1'b0;
    else                         ts_next = ctrl_q[B_TS];
    word_next[B_TS] = ts_next;
  end

  assign fp_trap   = insn_class == CLS_FP && (ctrl_q[B_EM] || ctrl_q[B_TS]);
  assign wait_trap = insn_class == CLS_WAIT && ctrl_q[B_MP] && ctrl_q[B_TS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= W'(cop32_strap) << B_ET;
      dna_pulse <= 1'b0;
      gp_pulse  <= 1'b0;
    end else begin
      ctrl_q    <= word_next;
      dna_pulse <= insn_valid && (fp_trap || wait_trap);
      gp_pulse  <= wr_bad;
    end
  end

  assign paging_on = ctrl_q[B_PG] && ctrl_q[B_PE];
  assign cop32_on  = ctrl_q[B_ET] && !ctrl_q[B_EM];

  AST_PG_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_PG] |-> ctrl_q[B_PE]); // R3
  AST_BAD_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad && !ts_event && !ts_clear |=> gp_pulse && $stable(ctrl_q)); // R3
  AST_TS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ts_event |=> ctrl_q[B_TS]); // R4
  AST_EM_TRAPS_FP: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_class == CLS_FP && ctrl_q[B_EM] |=> dna_pulse); // R6
  AST_WAIT_NO_MP: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_class == CLS_WAIT && !ctrl_q[B_MP] |=> !dna_pulse); // R8
  AST_IDLE_NO_DNA: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !dna_pulse); // R9
endmodule

// File: tb/mode_ctrl_trap_tb.sv
module mode_ctrl_trap_tb_top;
  logic clk = 0, rst_n = 0, cop32_strap = 1;
  logic wr_en = 0, ts_event = 0, ts_clear = 0, insn_valid = 0;
  logic [31:0] wr_data = 0;
  logic [1:0] insn_class = 0;
  logic [31:0] ctrl_q;
  logic dna_pulse, gp_pulse, paging_on, cop32_on;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mode_ctrl_trap dut_i (.clk(clk), .rst_n(rst_n), .cop32_strap(cop32_strap),
    .wr_en(wr_en), .wr_data(wr_data), .ts_event(ts_event), .ts_clear(ts_clear),
    .insn_valid(insn_valid), .insn_class(insn_class), .ctrl_q(ctrl_q),
    .dna_pulse(dna_pulse), .gp_pulse(gp_pulse), .paging_on(paging_on), .cop32_on(cop32_on));

  // {ts, em, mp, class[1:0], expected dna}
  localparam int NV = 12;
  localparam logic [5:0] VEC [NV] = '{
    6'b010_01_1, // R6
    6'b110_01_1, // R6
    6'b100_01_1, // R7
    6'b001_01_0, // R7
    6'b000_01_0, // R7
    6'b101_10_1, // R8
    6'b100_10_0, // R8
    6'b011_10_0, // R8
    6'b111_10_1, // R8
    6'b111_00_0, // R9
    6'b111_11_0, // R9
    6'b001_10_0  // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic insn(input logic [1:0] c, input logic v);
    insn_valid = v; insn_class = c;
    @(negedge clk);
    insn_valid = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strap1", ctrl_q, 32'h10);
    chk("R1 paging", {31'b0, paging_on}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 et", {31'b0, cop32_on}, 1);

    for (int i = 0; i < NV; i++) begin
      wr({28'b0, VEC[i][5], VEC[i][4], VEC[i][3], 1'b0});
      insn(VEC[i][2:1], 1'b1);
      chk($sformatf("R6-8 vector %0d dna", i), {31'b0, dna_pulse}, {31'b0, VEC[i][0]});
    end

    wr(32'h0000_000E);
    insn(2'b01, 1'b0);
    chk("R9 invalid", {31'b0, dna_pulse}, 0);

    wr(32'hFFFF_FFFF);
    chk("R2 mask", ctrl_q, 32'h8001_003F);
    chk("R10 on", {31'b0, paging_on}, 1);
    chk("R11 em", {31'b0, cop32_on}, 0);

    wr(32'h0001_0021);
    chk("R2 store", ctrl_q, 32'h0001_0021);
    chk("R10 off", {31'b0, paging_on}, 0);
    wr(32'h8000_0000);
    chk("R3 gp", {31'b0, gp_pulse}, 1);
    chk("R3 hold", ctrl_q, 32'h0001_0021);
    @(negedge clk);
    chk("R3 one cycle", {31'b0, gp_pulse}, 0);

    ts_event = 1; ts_clear = 1; wr_en = 1; wr_data = 32'h1;
    @(negedge clk);
    ts_event = 0; ts_clear = 0; wr_en = 0;
    chk("R4 wins", ctrl_q, 32'h9);
    ts_clear = 1;
    @(negedge clk);
    ts_clear = 0;
    chk("R5 clear", ctrl_q, 32'h1);
    ts_clear = 1; wr_en = 1; wr_data = 32'h9;
    @(negedge clk);
    ts_clear = 0; wr_en = 0;
    chk("R5 write wins", ctrl_q, 32'h9);
    ts_event = 1;
    @(negedge clk);
    ts_event = 0;
    wr(32'h10);
    chk("R11 et no em", {31'b0, cop32_on}, 1);

    rst_n = 0; cop32_strap = 0;
    repeat (2) @(negedge clk);
    chk("R1 strap0", ctrl_q, 32'h0);
    chk("R1 dna", {31'b0, dna_pulse}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule